// File: doc/BRIEF.md
# Stereo Serial Audio Input Receiver

This block takes a three-wire serial audio stream (bit clock, word select and one data line that carries left and right words in turn) and turns it into parallel stereo samples. All three lines are sampled by a fast system clock. The bit clock is never used as a clock. Each line passes through a two-stage synchroniser, and the rising edge of the bit clock is found by comparing the synchronised level with its previous value.

Each word is 16 bits of two's-complement data, most significant bit first. The level of word select names the channel: high means left and low means right. A change of word select closes the current word and opens the next one. When a complete left word is closed by word select falling, the two channel outputs are reloaded together in a single cycle and a one-cycle strobe is raised. A word that is too short sets a sticky error flag and is discarded.

Top module: `sdin_stereo_rx`

## Requirements
- R1: A synchronous reset (rst high at a clk edge) clears both channel outputs to zero and clears the strobe and the error flag.
- R2: A word is 16 bits and the first bit received is the most significant bit (bit 15) of the stored value.
- R3: Bits received while word select is high form the left word. Bits received while it is low form the right word.
- R4: Data and word select are taken only on a rising edge of the bit clock. Changes on the data line between rising edges have no effect on the stored values.
- R5: Both outputs change only together, in the cycle in which sample_vld_o is high. The strobe lasts one cycle and appears only when a falling edge of word select closes a complete left word. left_o then takes that left word and right_o takes the last complete right word.
- R6: If a word has more than 16 bits before word select changes, only the last 16 bits received are kept.
- R7: If a word closes with fewer than 16 bits, frame_err_o goes high and stays high until reset. That channel's stored word keeps its old value. A short left word produces no strobe and no output change.
- R8: Bits before the first change of word select after reset are discarded, and raise no error.
- R9: Outputs reflect a bit-clock rising edge on the second clk edge after the first clk edge that samples bck_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst | input | 1 | Synchronous reset, active high |
| bck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Word select: high = left, low = right |
| sd_i | input | 1 | Serial data, MSB first |
| left_o | output | 16 | Left sample, two's complement |
| right_o | output | 16 | Right sample, two's complement |
| sample_vld_o | output | 1 | One-cycle strobe on the joint output update |
| frame_err_o | output | 1 | Sticky short-word flag |

## Verification
The commit of a finished left word and the joint output transfer happen on the same bit-clock edge. A bug there would put the previous left word, not the one just closed, on left_o. The bench provokes this on every frame by sending one left word after another with different values. A behavioural model built on bit queues is compared with the outputs on every clock. A short right word followed by a full left word also places an error and a transfer close together, and the bench checks that right_o keeps its older value.

// File: rtl/sdin_pkg.sv
package sdin_pkg;
    typedef struct packed {
        logic bck;
        logic ws;
        logic sd;
    } lines_t;
endpackage

// File: rtl/sdin_line_sync.sv
module sdin_line_sync
    import sdin_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  lines_t raw_i,
    output lines_t sync_o,
    output logic   bck_rise_o
);
    typedef struct packed {
        lines_t [STAGES-1:0] pipe;
        logic                bck_last;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
        st_d.bck_last = st_q.pipe[STAGES-1].bck;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sync_o     = st_q.pipe[STAGES-1];
    assign bck_rise_o = sync_o.bck & ~st_q.bck_last;

    AST_RISE_SPACED: assert property (@(posedge clk) disable iff (rst)
        bck_rise_o |=> !bck_rise_o); // R4
endmodule

// File: rtl/sdin_word_shifter.sv
module sdin_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en_i,
    input  logic              restart_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o,
    output logic              full_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [CNT_W-1:0]  cnt;
    } shf_st_t;

    shf_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en_i) begin
            st_d.word = {st_q.word[WORD_W-2:0], bit_i};
            if (restart_i)                st_d.cnt = CNT_W'(1);
            else if (st_q.cnt != CNT_FULL) st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word_o = st_q.word;
    assign full_o = (st_q.cnt == CNT_FULL);

    AST_RESTART_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        (shift_en_i && restart_i) |=> !full_o); // R7
endmodule

// File: rtl/sdin_stereo_rx.sv
module sdin_stereo_rx
    import sdin_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bck_i,
    input  logic              ws_i,
    input  logic              sd_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              sample_vld_o,
    output logic              frame_err_o
);
    typedef struct packed {
        logic [WORD_W-1:0] in_l;
        logic [WORD_W-1:0] in_r;
        logic [WORD_W-1:0] out_l;
        logic [WORD_W-1:0] out_r;
        logic              ws_cur;
        logic              armed;
        logic              vld;
        logic              err;
    } core_st_t;

    lines_t            raw, lines;
    logic              bck_rise;
    logic              boundary;
    logic [WORD_W-1:0] word;
    logic              word_full;
    core_st_t          c_d, c_q;

    assign raw = '{bck: bck_i, ws: ws_i, sd: sd_i};

    sdin_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .raw_i      (raw),
        .sync_o     (lines),
        .bck_rise_o (bck_rise)
    );

    assign boundary = bck_rise && (lines.ws != c_q.ws_cur);

    sdin_word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .shift_en_i (bck_rise),
        .restart_i  (boundary),
        .bit_i      (lines.sd),
        .word_o     (word),
        .full_o     (word_full)
    );

    always_comb begin
        c_d     = c_q;
        c_d.vld = 1'b0;
        if (boundary) begin
            if (c_q.armed) begin
                if (!word_full) begin
                    c_d.err = 1'b1;
                end else if (c_q.ws_cur) begin
                    c_d.in_l  = word;
                    c_d.out_l = word;
                    c_d.out_r = c_q.in_r;
                    c_d.vld   = 1'b1;
                end else begin
                    c_d.in_r = word;
                end
            end
            c_d.armed  = 1'b1;
            c_d.ws_cur = lines.ws;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) c_q <= '0;
        else     c_q <= c_d;
    end

    assign left_o       = c_q.out_l;
    assign right_o      = c_q.out_r;
    assign sample_vld_o = c_q.vld;
    assign frame_err_o  = c_q.err;

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_vld_o |=> !sample_vld_o); // R5
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sample_vld_o && !$past(rst)) |-> ($stable(left_o) && $stable(right_o))); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |=> frame_err_o); // R7
    AST_VLD_AFTER_BCK: assert property (@(posedge clk) disable iff (rst)
        sample_vld_o |-> ($past(bck_rise) && $past(lines.bck))); // R4
endmodule

// File: tb/sdin_stereo_rx_tb_top.sv
module sdin_stereo_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bck = 1'b0, ws = 1'b0, sd = 1'b0;
    logic [15:0] left_o, right_o;
    logic        sample_vld_o, frame_err_o;

    int n_chk = 0, n_bad = 0, vld_seen = 0;
    bit started = 1'b0;

    always #4 clk = ~clk;

    sdin_stereo_rx dut_i (
        .clk(clk), .rst(rst), .bck_i(bck), .ws_i(ws), .sd_i(sd),
        .left_o(left_o), .right_o(right_o),
        .sample_vld_o(sample_vld_o), .frame_err_o(frame_err_o)
    );

    // behavioural reference: input history and a bit queue per word
    logic        h1b, h2b, h3b, h1w, h2w, h1d, h2d;
    bit          m_bits[$];
    logic [15:0] m_inl, m_inr, m_outl, m_outr, val;
    logic        m_ws, m_armed, m_vld, m_err;

    always @(posedge clk) begin
        if (rst) begin
            {h1b, h2b, h3b, h1w, h2w, h1d, h2d} = '0;
            m_bits.delete();
            {m_inl, m_inr, m_outl, m_outr} = '0;
            {m_ws, m_armed, m_vld, m_err} = '0;
            started = 1'b1;
        end else begin
            m_vld = 1'b0;
            if (h2b && !h3b) begin
                if (h2w != m_ws) begin
                    if (m_armed) begin
                        if (m_bits.size() >= 16) begin
                            val = '0;
                            foreach (m_bits[i]) val = {val[14:0], m_bits[i]};
                            if (m_ws) begin
                                m_inl = val; m_outl = val; m_outr = m_inr; m_vld = 1'b1;
                            end else begin
                                m_inr = val;
                            end
                        end else begin
                            m_err = 1'b1;
                        end
                    end
                    m_armed = 1'b1;
                    m_ws = h2w;
                    m_bits.delete();
                end
                m_bits.push_back(h2d);
                if (m_bits.size() > 16) void'(m_bits.pop_front());
            end
            h3b = h2b; h2b = h1b; h2w = h1w; h2d = h1d;
            h1b = bck; h1w = ws; h1d = sd;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // every-clock comparison; the two-edge delay of the model covers R9
    always @(negedge clk) begin
        if (started) begin
            chk("R2/R3 left",  32'(left_o),  32'(m_outl));
            chk("R3 right",    32'(right_o), 32'(m_outr));
            chk("R5 strobe",   32'(sample_vld_o), 32'(m_vld));
            chk("R7 error",    32'(frame_err_o),  32'(m_err));
            if (sample_vld_o === 1'b1) vld_seen++;
        end
    end

    task automatic send(input logic w, input logic [31:0] v, input int n, input bit glitch);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); bck = 1'b0; ws = w; sd = glitch ? ~v[i] : v[i];
            @(negedge clk); sd = v[i];
            @(negedge clk);
            @(negedge clk); bck = 1'b1;
            @(negedge clk); if (glitch) sd = ~v[i];
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
    endtask

    int snap;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 left", 32'(left_o), 0);
        chk("R1 right", 32'(right_o), 0);
        chk("R1 err", 32'(frame_err_o), 0);

        send(1'b0, 32'h15, 5, 1'b0);      // partial word before arming (R8)
        send(1'b1, 32'h8001, 16, 1'b0);
        send(1'b0, 32'h1234, 16, 1'b0);
        chk("R5 first frame left", 32'(left_o), 32'h8001);
        send(1'b1, 32'hA5C3, 16, 1'b0);
        send(1'b0, 32'h7FFE, 16, 1'b0);
        chk("R2 left", 32'(left_o), 32'hA5C3);
        chk("R3 right", 32'(right_o), 32'h1234);
        chk("R8 no error", 32'(frame_err_o), 0);
        chk("R5 strobes", 32'(vld_seen), 2);

        send(1'b1, 32'h5A5A, 16, 1'b1);   // data glitches between rises
        send(1'b0, 32'h0F0F, 16, 1'b1);
        chk("R4 left", 32'(left_o), 32'h5A5A);
        chk("R4 right", 32'(right_o), 32'h7FFE);

        send(1'b1, 32'hABCDE, 20, 1'b0);  // over-long left word
        send(1'b0, 32'h3333, 16, 1'b0);
        chk("R6 left", 32'(left_o), 32'hBCDE);
        chk("R6 right", 32'(right_o), 32'h0F0F);

        send(1'b1, 32'h4444, 16, 1'b0);
        send(1'b0, 32'h2AA, 10, 1'b0);    // short right word
        send(1'b1, 32'h5555, 16, 1'b0);
        chk("R7 error set", 32'(frame_err_o), 1);
        send(1'b0, 32'h6666, 16, 1'b0);
        chk("R7 left", 32'(left_o), 32'h5555);
        chk("R7 right kept", 32'(right_o), 32'h3333);

        snap = vld_seen;
        send(1'b1, 32'h12, 8, 1'b0);      // short left word
        send(1'b0, 32'h7777, 16, 1'b0);
        chk("R7 no strobe", 32'(vld_seen), 32'(snap));
        chk("R7 left held", 32'(left_o), 32'h5555);
        chk("R7 right held", 32'(right_o), 32'h3333);

        do_reset();
        @(negedge clk);
        chk("R1 left after reset", 32'(left_o), 0);
        chk("R1 right after reset", 32'(right_o), 0);
        chk("R1 err after reset", 32'(frame_err_o), 0);
        send(1'b0, 32'h3, 3, 1'b0);       // unarmed right fragment
        send(1'b1, 32'hCAFE, 16, 1'b0);
        send(1'b0, 32'hBEEF, 16, 1'b0);
        chk("R8 no error after fragment", 32'(frame_err_o), 0);
        chk("R8 left", 32'(left_o), 32'hCAFE);
        repeat (10) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule